// File: doc/BRIEF.md
# Video Processor Status and Data Read Port

This block is the processor-facing read side of a tile-based video processor. It serves two kinds of read. A status read packs three live flags into one byte: vertical blank, sprite-zero hit and sprite overflow. That read also has side effects. It asks the flag owner to clear the vertical-blank flag and to reset the shared first/second write toggle. When it lands at the very start of vertical blank, it cancels the pending NMI.

A data read goes through a one-deep read-ahead buffer for pattern and nametable space. Each such read hands back the byte fetched by the previous data read and then refills the buffer. Palette space is the exception. A palette read returns the palette entry at once, masked by the grayscale mask, while the buffer is refilled from the nametable byte that lies beneath it. Every data read advances the internal video address by 1 or by 32.

Requests arrive on a valid/ready channel. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Only one request is in flight at a time. `req_ready` stays low from acceptance until the response has been handed over. Responses leave on a second valid/ready channel. `rsp_valid` rises two cycles after acceptance, and `rsp_data` holds still for as long as `rsp_ready` is low. Pattern, nametable and palette memories are external synchronous reads: an address and enable in one cycle, data the next.

Top module: `vid_read_port`

## Requirements
- R1: A status read returns bit 7 = `flag_vblank`, bit 6 = `flag_spr0`, bit 5 = `flag_sprovf`, bits 4..0 = 0, with the flags sampled in the acceptance cycle. The response is valid two cycles after acceptance.
- R2: A status read pulses `vblank_clear` and `toggle_clear` high for exactly the cycle after acceptance. A data read pulses neither.
- R3: `nmi_cancel` pulses in the cycle after a status read only if, when it was accepted, `scan_line` equalled VBL_LINE (241) and `scan_dot` was 3 or less.
- R4: A data read at an address outside palette space returns the buffer contents left by the previous data read (0x00 after reset). It then reloads the buffer from address AND 0x3FFF: pattern memory at bits 12..0 when that value is below 0x2000, and nametable memory at bits 13..0 otherwise.
- R5: A data read whose address satisfies (address AND 0x3F00) = 0x3F00 returns the palette entry ANDed with `gray_mask`, with no buffer delay.
- R6: The palette index is address AND 0x0C when address bits 1..0 are 00, and address AND 0x1F otherwise.
- R7: A palette-space data read refills the buffer from address AND 0x2FFF. That read goes to pattern memory below 0x2000 and to nametable memory otherwise, and the next buffered read returns the refilled byte.
- R8: After each accepted data read, `vaddr` advances by 1 when `step_down` = 0 and by 32 when `step_down` = 1, wrapping within 15 bits. A status read leaves `vaddr` unchanged.
- R9: `vaddr_load` writes `vaddr_load_val` into `vaddr` at the next edge. If it coincides with an accepted data read, the read uses the old address and the loaded value wins over the increment.
- R10: `req_ready` is low while a request is in flight or a response is stalled. `rsp_valid` and `rsp_data` hold while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_is_data | input | 1 | 1 = data port read, 0 = status read |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Response byte |
| flag_vblank | input | 1 | Vertical-blank flag |
| flag_spr0 | input | 1 | Sprite-zero hit flag |
| flag_sprovf | input | 1 | Sprite overflow flag |
| scan_line | input | 9 | Current scanline |
| scan_dot | input | 9 | Current dot within the scanline |
| vblank_clear | output | 1 | Pulse: clear the vertical-blank flag |
| toggle_clear | output | 1 | Pulse: reset the write toggle |
| nmi_cancel | output | 1 | Pulse: drop the NMI raised this frame |
| step_down | input | 1 | Address increment select: 0 = 1, 1 = 32 |
| gray_mask | input | 8 | Mask applied to palette reads |
| vaddr_load | input | 1 | Load the video address |
| vaddr_load_val | input | 15 | Value to load |
| vaddr | output | 15 | Current video address |
| pat_rd_en | output | 1 | Pattern memory read enable |
| pat_rd_addr | output | 13 | Pattern memory address |
| pat_rd_data | input | 8 | Pattern data, one cycle after enable |
| nt_rd_en | output | 1 | Nametable memory read enable |
| nt_rd_addr | output | 14 | Nametable memory address |
| nt_rd_data | input | 8 | Nametable data, one cycle after enable |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_addr | output | 5 | Mirrored palette index |
| pal_rd_data | input | 8 | Palette data, one cycle after enable |

## Verification
An address load and an accepted data read can fall on the same clock edge. Both then act on the video address: the read's fetch and refill must use the old address, while the stored address must take the loaded value rather than the incremented one. The bench raises `vaddr_load` in the very cycle a data request is accepted. It then judges `vaddr` right after that edge, the returned byte, and the following buffered read, which must carry the pattern byte fetched from the pre-load address.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    REFILL_PAT = 1'b0,
    REFILL_NT  = 1'b1
  } refill_src_e;

  typedef struct packed {
    logic              is_data;
    logic              is_pal;
    refill_src_e       src;
    logic [BYTE_W-1:0] stat;
    logic [BYTE_W-1:0] mask;
  } stage_t;
endpackage

// File: rtl/vrp_addr_map.sv
module vrp_addr_map
  import vrp_pkg::*;
#(
  parameter int VADDR_W = 15,
  parameter int PAT_AW  = 13,
  parameter int NT_AW   = 14,
  parameter int PAL_AW  = 5
) (
  input  logic [VADDR_W-1:0] addr,
  output logic               is_pal,
  output logic [PAL_AW-1:0]  pal_idx,
  output refill_src_e        src,
  output logic [PAT_AW-1:0]  pat_addr,
  output logic [NT_AW-1:0]   nt_addr
);
  logic [NT_AW-1:0] refill;

  always_comb begin
    is_pal = &addr[13:8];
    if (addr[1:0] == 2'b00) pal_idx = {1'b0, addr[3:2], 2'b00};
    else                    pal_idx = addr[PAL_AW-1:0];
    if (is_pal) refill = {addr[13], 1'b0, addr[11:0]};
    else        refill = addr[NT_AW-1:0];
    src      = refill[13] ? REFILL_NT : REFILL_PAT;
    pat_addr = refill[PAT_AW-1:0];
    nt_addr  = refill;
  end
endmodule

// File: rtl/vrp_addr_reg.sv
module vrp_addr_reg #(
  parameter int VADDR_W    = 15,
  parameter int STEP_SMALL = 1,
  parameter int STEP_LARGE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [VADDR_W-1:0] load_val,
  input  logic               step,
  input  logic               step_down,
  output logic [VADDR_W-1:0] addr
);
  localparam logic [VADDR_W-1:0] INC_S = VADDR_W'(STEP_SMALL);
  localparam logic [VADDR_W-1:0] INC_L = VADDR_W'(STEP_LARGE);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + (step_down ? INC_L : INC_S);
  end
endmodule

// File: rtl/vrp_status_fx.sv
module vrp_status_fx
  import vrp_pkg::*;
#(
  parameter int POS_W       = 9,
  parameter int VBL_LINE    = 241,
  parameter int NMI_DOT_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              vblank,
  input  logic              spr0,
  input  logic              sprovf,
  input  logic [POS_W-1:0]  line,
  input  logic [POS_W-1:0]  dot,
  output logic [BYTE_W-1:0] stat,
  output logic              vblank_clear,
  output logic              toggle_clear,
  output logic              nmi_cancel
);
  localparam logic [POS_W-1:0] LINE_V = POS_W'(VBL_LINE);
  localparam logic [POS_W-1:0] DOT_V  = POS_W'(NMI_DOT_MAX);

  logic in_window;

  always_comb begin
    stat      = {vblank, spr0, sprovf, {(BYTE_W-3){1'b0}}};
    in_window = (line == LINE_V) && (dot <= DOT_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank_clear <= 1'b0;
      toggle_clear <= 1'b0;
      nmi_cancel   <= 1'b0;
    end else begin
      vblank_clear <= take;
      toggle_clear <= take;
      nmi_cancel   <= take && in_window;
    end
  end
endmodule

// File: rtl/vid_read_port.sv
module vid_read_port
  import vrp_pkg::*;
#(
  parameter int VADDR_W     = 15,
  parameter int PAT_AW      = 13,
  parameter int NT_AW       = 14,
  parameter int PAL_AW      = 5,
  parameter int POS_W       = 9,
  parameter int VBL_LINE    = 241,
  parameter int NMI_DOT_MAX = 3,
  parameter int STEP_LARGE  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data,
  input  logic               flag_vblank,
  input  logic               flag_spr0,
  input  logic               flag_sprovf,
  input  logic [POS_W-1:0]   scan_line,
  input  logic [POS_W-1:0]   scan_dot,
  output logic               vblank_clear,
  output logic               toggle_clear,
  output logic               nmi_cancel,
  input  logic               step_down,
  input  logic [7:0]         gray_mask,
  input  logic               vaddr_load,
  input  logic [VADDR_W-1:0] vaddr_load_val,
  output logic [VADDR_W-1:0] vaddr,
  output logic               pat_rd_en,
  output logic [PAT_AW-1:0]  pat_rd_addr,
  input  logic [7:0]         pat_rd_data,
  output logic               nt_rd_en,
  output logic [NT_AW-1:0]   nt_rd_addr,
  input  logic [7:0]         nt_rd_data,
  output logic               pal_rd_en,
  output logic [PAL_AW-1:0]  pal_rd_addr,
  input  logic [7:0]         pal_rd_data
);
  logic              accept, take_data, take_stat;
  logic              s1_valid_q, rsp_valid_q;
  stage_t            s1_q;
  logic [BYTE_W-1:0] rsp_data_q, buf_q, stat_byte, fetched;
  logic              map_pal;
  refill_src_e       map_src;

  assign req_ready = !s1_valid_q && (!rsp_valid_q || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign take_data = accept && req_is_data;
  assign take_stat = accept && !req_is_data;

  vrp_addr_map #(.VADDR_W(VADDR_W), .PAT_AW(PAT_AW), .NT_AW(NT_AW), .PAL_AW(PAL_AW)) u_map (
    .addr     (vaddr),
    .is_pal   (map_pal),
    .pal_idx  (pal_rd_addr),
    .src      (map_src),
    .pat_addr (pat_rd_addr),
    .nt_addr  (nt_rd_addr)
  );

  vrp_addr_reg #(.VADDR_W(VADDR_W), .STEP_SMALL(1), .STEP_LARGE(STEP_LARGE)) u_areg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (vaddr_load),
    .load_val  (vaddr_load_val),
    .step      (take_data),
    .step_down (step_down),
    .addr      (vaddr)
  );

  vrp_status_fx #(.POS_W(POS_W), .VBL_LINE(VBL_LINE), .NMI_DOT_MAX(NMI_DOT_MAX)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take_stat),
    .vblank       (flag_vblank),
    .spr0         (flag_spr0),
    .sprovf       (flag_sprovf),
    .line         (scan_line),
    .dot          (scan_dot),
    .stat         (stat_byte),
    .vblank_clear (vblank_clear),
    .toggle_clear (toggle_clear),
    .nmi_cancel   (nmi_cancel)
  );

  assign pal_rd_en = take_data && map_pal;
  assign pat_rd_en = take_data && (map_src == REFILL_PAT);
  assign nt_rd_en  = take_data && (map_src == REFILL_NT);

  assign fetched = (s1_q.src == REFILL_NT) ? nt_rd_data : pat_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_q       <= '0;
    end else begin
      s1_valid_q <= accept;
      if (accept) begin
        s1_q.is_data <= req_is_data;
        s1_q.is_pal  <= map_pal;
        s1_q.src     <= map_src;
        s1_q.stat    <= stat_byte;
        s1_q.mask    <= gray_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      buf_q       <= '0;
    end else begin
      if (s1_valid_q) begin
        rsp_valid_q <= 1'b1;
        if (!s1_q.is_data)    rsp_data_q <= s1_q.stat;
        else if (s1_q.is_pal) rsp_data_q <= pal_rd_data & s1_q.mask;
        else                  rsp_data_q <= buf_q;
        if (s1_q.is_data) buf_q <= fetched;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/vid_read_port_chk.sv
module vid_read_port_chk #(
  parameter int VADDR_W    = 15,
  parameter int PAL_AW     = 5,
  parameter int POS_W      = 9,
  parameter int VBL_LINE   = 241,
  parameter int NMI_DOT_MAX = 3,
  parameter int STEP_LARGE = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_is_data,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [7:0]         rsp_data,
  input logic [POS_W-1:0]   scan_line,
  input logic [POS_W-1:0]   scan_dot,
  input logic               vblank_clear,
  input logic               nmi_cancel,
  input logic               step_down,
  input logic               vaddr_load,
  input logic [VADDR_W-1:0] vaddr_load_val,
  input logic [VADDR_W-1:0] vaddr,
  input logic               pat_rd_en,
  input logic               nt_rd_en,
  input logic               pal_rd_en,
  input logic [PAL_AW-1:0]  pal_rd_addr
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10
  AST_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_clear |-> $past(req_valid && req_ready && !req_is_data)); // R2
  AST_NMI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_cancel |-> $past(req_valid && req_ready && !req_is_data &&
                         scan_line == POS_W'(VBL_LINE) && scan_dot <= POS_W'(NMI_DOT_MAX))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_is_data && !vaddr_load |=>
      vaddr == VADDR_W'($past(vaddr) + ($past(step_down) ? VADDR_W'(STEP_LARGE) : VADDR_W'(1)))); // R8
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vaddr_load |=> vaddr == $past(vaddr_load_val)); // R9
  AST_PAL_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |-> $onehot({pat_rd_en, nt_rd_en})); // R7
  AST_PAL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en && pal_rd_addr[1:0] == 2'b00 |-> !pal_rd_addr[4]); // R6
endmodule

bind vid_read_port vid_read_port_chk #(
  .VADDR_W(VADDR_W), .PAL_AW(PAL_AW), .POS_W(POS_W),
  .VBL_LINE(VBL_LINE), .NMI_DOT_MAX(NMI_DOT_MAX), .STEP_LARGE(STEP_LARGE)
) u_chk (.*);

// File: tb/vid_read_port_bench.sv
module vid_read_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_data = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic        flag_vblank = 1'b0, flag_spr0 = 1'b0, flag_sprovf = 1'b0;
  logic [8:0]  scan_line = '0, scan_dot = '0;
  logic        vblank_clear, toggle_clear, nmi_cancel;
  logic        step_down = 1'b0;
  logic [7:0]  gray_mask = 8'hFF;
  logic        vaddr_load = 1'b0;
  logic [14:0] vaddr_load_val = '0;
  logic [14:0] vaddr;
  logic        pat_rd_en, nt_rd_en, pal_rd_en;
  logic [12:0] pat_rd_addr;
  logic [13:0] nt_rd_addr;
  logic [4:0]  pal_rd_addr;
  logic [7:0]  pat_rd_data, nt_rd_data, pal_rd_data;

  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [7:0] exp_buf = 8'h00;
  logic seen_vc, seen_tc, seen_nc;

  always #10 clk = ~clk;

  vid_read_port u_vid_read_port (.*);

  function automatic logic [7:0] pat_f(input logic [12:0] a);
    return 8'(a ^ (a >> 5)) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] nt_f(input logic [13:0] a);
    return 8'(a[7:0] + a[13:6]) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] pal_f(input logic [4:0] i);
    return {3'b110, i};
  endfunction
  function automatic logic [7:0] refill_f(input logic [13:0] r);
    return (r < 14'h2000) ? pat_f(r[12:0]) : nt_f(r);
  endfunction

  always_ff @(posedge clk) begin
    pat_rd_data <= pat_f(pat_rd_addr);
    nt_rd_data  <= nt_f(nt_rd_addr);
    pal_rd_data <= pal_f(pal_rd_addr);
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic d, output logic [7:0] q);
    @(negedge clk);
    req_is_data = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    seen_vc = vblank_clear; seen_tc = toggle_clear; seen_nc = nmi_cancel;
    while (!rsp_valid) @(negedge clk);
    q = rsp_data;
  endtask

  task automatic load(input logic [14:0] a);
    @(negedge clk);
    vaddr_load = 1'b1; vaddr_load_val = a;
    @(negedge clk);
    vaddr_load = 1'b0;
  endtask

  // Expected data read at the current address, updating the buffer model
  task automatic data_expect(input string tag, input logic [14:0] a);
    logic [7:0] q, e;
    logic [4:0] idx;
    idx = (a[1:0] == 2'b00) ? {1'b0, a[3:2], 2'b00} : a[4:0];
    if ((a & 15'h3F00) == 15'h3F00) begin
      e = pal_f(idx) & gray_mask;
      rd(1'b1, q);
      check(tag, {8'h0, q}, {8'h0, e});
      exp_buf = refill_f(a[13:0] & 14'h2FFF);
    end else begin
      e = exp_buf;
      rd(1'b1, q);
      check(tag, {8'h0, q}, {8'h0, e});
      exp_buf = refill_f(a[13:0] & 14'h3FFF);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset rsp_valid", {15'h0, rsp_valid}, 16'h0);
    check("R10 reset req_ready", {15'h0, req_ready}, 16'h1);
    check("R8 reset vaddr", {1'b0, vaddr}, 16'h0);
    check("R2 reset clears", {14'h0, vblank_clear, toggle_clear}, 16'h0);
  endtask

  task automatic t_status;
    logic [7:0] q;
    scan_line = 9'd10; scan_dot = 9'd1;
    flag_vblank = 1'b1; flag_spr0 = 1'b0; flag_sprovf = 1'b1;
    rd(1'b0, q);
    check("R1 status 101", {8'h0, q}, 16'h00A0);
    check("R2 status clears", {14'h0, seen_vc, seen_tc}, 16'h3);
    check("R3 no cancel off line", {15'h0, seen_nc}, 16'h0);
    flag_vblank = 1'b0; flag_spr0 = 1'b1; flag_sprovf = 1'b0;
    rd(1'b0, q);
    check("R1 status 010", {8'h0, q}, 16'h0040);
    check("R8 status keeps vaddr", {1'b0, vaddr}, 16'h0);
  endtask

  task automatic t_nmi;
    logic [7:0] q;
    scan_line = 9'd241; scan_dot = 9'd3;
    rd(1'b0, q);
    check("R3 cancel dot 3", {15'h0, seen_nc}, 16'h1);
    scan_dot = 9'd4;
    rd(1'b0, q);
    check("R3 no cancel dot 4", {15'h0, seen_nc}, 16'h0);
    scan_line = 9'd240; scan_dot = 9'd0;
    rd(1'b0, q);
    check("R3 no cancel line 240", {15'h0, seen_nc}, 16'h0);
    scan_line = 9'd0;
  endtask

  task automatic t_buffered;
    step_down = 1'b0;
    load(15'h0100);
    data_expect("R4 first read returns reset buffer", 15'h0100);
    check("R2 data read no clear", {14'h0, seen_vc, seen_tc}, 16'h0);
    data_expect("R4 pattern byte delayed", 15'h0101);
    data_expect("R4 pattern byte delayed 2", 15'h0102);
    check("R8 step across", {1'b0, vaddr}, 16'h0103);
    step_down = 1'b1;
    load(15'h2345);
    data_expect("R4 switch to nametable", 15'h2345);
    data_expect("R4 nametable byte delayed", 15'h2365);
    check("R8 step down", {1'b0, vaddr}, 16'h2385);
    step_down = 1'b0;
  endtask

  task automatic t_palette;
    gray_mask = 8'h3F;
    load(15'h3F10);
    data_expect("R5 R6 palette 0x10 mirrors to 0x00", 15'h3F10);
    load(15'h3F05);
    data_expect("R5 R6 palette 0x05", 15'h3F05);
    load(15'h0000);
    data_expect("R7 buffer holds nametable under palette", 15'h0000);
    gray_mask = 8'hFF;
    load(15'h7F1C);
    data_expect("R6 palette 0x1C mirrors to 0x0C", 15'h7F1C);
    data_expect("R6 palette 0x1D", 15'h7F1D);
  endtask

  task automatic t_wrap;
    step_down = 1'b0;
    load(15'h7FFF);
    data_expect("R5 palette at top", 15'h7FFF);
    check("R8 wrap across", {1'b0, vaddr}, 16'h0000);
    data_expect("R7 refill from 0x2FFF", 15'h0000);
    step_down = 1'b1;
    load(15'h7FF0);
    data_expect("R5 palette 0x10 at top", 15'h7FF0);
    check("R8 wrap down", {1'b0, vaddr}, 16'h0010);
    step_down = 1'b0;
  endtask

  task automatic t_stall;
    logic [7:0] snap;
    flag_vblank = 1'b1; flag_spr0 = 1'b1; flag_sprovf = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0; req_is_data = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 response valid", {15'h0, rsp_valid}, 16'h1);
    snap = rsp_data;
    check("R1 status 111", {8'h0, snap}, 16'h00E0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 stalled hold", {7'h0, rsp_valid, rsp_data}, {8'h01, snap});
      check("R10 stalled not ready", {15'h0, req_ready}, 16'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {14'h0, rsp_valid, req_ready}, 16'h1);
    flag_vblank = 1'b0; flag_spr0 = 1'b0; flag_sprovf = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] e;
    step_down = 1'b0;
    load(15'h0200);
    @(negedge clk);
    req_is_data = 1'b1; req_valid = 1'b1;
    vaddr_load = 1'b1; vaddr_load_val = 15'h1234;
    @(negedge clk);
    req_valid = 1'b0; vaddr_load = 1'b0;
    check("R9 load wins over step", {1'b0, vaddr}, 16'h1234);
    e = exp_buf;
    while (!rsp_valid) @(negedge clk);
    check("R9 read used old buffer", {8'h0, rsp_data}, {8'h0, e});
    exp_buf = pat_f(13'h0200);
    data_expect("R9 refill from pre-load address", 15'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_nmi();
    t_buffered();
    t_palette();
    t_wrap();
    t_stall();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule